// File: doc/BRIEF.md
# Flash Erase Status Bit Generator

This block is the device-side logic that supplies the status bits a host sees on data reads while a flash bank runs an embedded program or erase. It tracks the operating mode of the bank: idle, programming, waiting out the sector-erase acceptance window, erasing, erase-suspended, or programming while erase-suspended. It also keeps a mask of the sectors picked for erase. The array, the high-voltage pulse sequencer and the command decoder sit outside the block. Each of them shows up here as a one-cycle strobe, raised in the cycle that follows the final write-enable rising edge of its command sequence.

On every status read, a read cycle ends with a one-cycle pulse on either the output-enable strobe or the chip-enable strobe. On that read the block updates two toggle bits. The first toggle bit (`st_tgl_act`) tells the host that an embedded operation is running, but not which sectors are involved. The second toggle bit (`st_tgl_sec`) tells the host that the addressed sector is marked for erase, but not whether the erase is running or suspended. The host needs both bits to learn the sector and the mode together.

A timeout flag latches a pulse-limit failure until a reset command arrives. An erase-timer bit shows whether the window for adding more sectors has closed and the erase has begun.

Top module: `flash_status_gen`

## Requirements
- R1: After reset, `stat_sel`, `st_tgl_act`, `st_tgl_sec`, `st_timeout` and `st_erase_go` are all 0. Reads in the idle mode change none of them.
- R2: While programming, erase-window waiting, erasing, or programming inside a suspend, each read inverts `st_tgl_act` one cycle after the strobe, whatever the address. A read ends on `rd_oe_end`, `rd_ce_end` or both, and a read with both strobes in the same cycle counts as one read.
- R3: While erase-suspended, reads leave `st_tgl_act` unchanged.
- R4: In the erase-window, erasing and erase-suspended modes, a read whose `sec_addr` is marked in the erase mask inverts `st_tgl_sec` one cycle after the strobe.
- R5: A read of an unmarked sector leaves `st_tgl_sec` unchanged. So does any read in a program mode.
- R6: `sec_erase_cmd` in idle starts an erase window with only `sec_addr` marked. In the window it adds `sec_addr` to the mask and restarts the window. `st_erase_go` stays 0 until TMO_CYC cycles after the last sector command, becomes 1 then, and stays 1 through erase suspend.
- R7: `pulse_over` in a program or erase mode sets `st_timeout` to 1. The flag holds until `reset_cmd`. While it is set, `op_done` is ignored and the toggle bits keep toggling.
- R8: `reset_cmd` with `st_timeout` set clears the flag. From a program inside a suspend it returns to erase-suspended with the mask kept. From any other mode it returns to idle (`stat_sel` = 0) with the mask cleared.
- R9: `op_done` ends a program or erase and clears `stat_sel`. After that, reads change neither toggle bit, and a completed erase clears the mask.
- R10: `erase_susp` moves the window or erase mode to erase-suspended. `erase_resume` returns it to erasing. `prog_start` while suspended starts a program inside the suspend, and `op_done` then returns the bank to erase-suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_addr | input | SEC_W | Sector of the current read or sector-erase command |
| rd_oe_end | input | 1 | Read cycle ended by output enable (one-cycle pulse) |
| rd_ce_end | input | 1 | Read cycle ended by chip enable (one-cycle pulse) |
| prog_start | input | 1 | Program command sequence completed |
| sec_erase_cmd | input | 1 | Sector-erase command sequence completed for `sec_addr` |
| erase_susp | input | 1 | Erase suspend command |
| erase_resume | input | 1 | Erase resume command |
| op_done | input | 1 | Embedded operation finished successfully |
| pulse_over | input | 1 | Pulse-count limit exceeded |
| reset_cmd | input | 1 | Reset command |
| stat_sel | output | 1 | 1 when reads return status rather than array data |
| st_tgl_act | output | 1 | Toggle bit for an active operation |
| st_tgl_sec | output | 1 | Toggle bit for a sector marked for erase |
| st_timeout | output | 1 | Latched pulse-limit failure |
| st_erase_go | output | 1 | Erase window closed, erase begun |

## Verification
A wrong mode register shows up on the first read after the faulty transition. The active-toggle bit inverts or holds against the prediction, and `stat_sel` or `st_erase_go` disagree in the same cycle. A corrupted erase mask is caught by sweeping reads over every sector in each erase mode: on the first wrong sector, `st_tgl_sec` toggles or holds against the prediction. A timer off by even one cycle is caught by sampling `st_erase_go` one cycle before and exactly at the expected edge, after both a single sector command and a restarted window.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  typedef enum logic [2:0] {
    M_IDLE   = 3'd0,
    M_PROG   = 3'd1,
    M_WIN    = 3'd2,
    M_ERASE  = 3'd3,
    M_SUSP   = 3'd4,
    M_SPROG  = 3'd5
  } fsg_mode_e;
endpackage

// File: rtl/fsg_mode_ctl.sv
module fsg_mode_ctl
  import fsg_pkg::*;
#(
  parameter int TMO_CYC = 16,
  localparam int TW = (TMO_CYC > 1) ? $clog2(TMO_CYC) : 1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      prog_start,
  input  logic      sec_erase_cmd,
  input  logic      erase_susp,
  input  logic      erase_resume,
  input  logic      op_done,
  input  logic      pulse_over,
  input  logic      reset_cmd,
  output fsg_mode_e mode,
  output logic      timeout,
  output logic      mask_add,
  output logic      mask_clr
);
  localparam logic [TW-1:0] TLOAD = TW'(TMO_CYC - 1);

  fsg_mode_e mode_q, mode_d;
  logic      tmo_q, tmo_d;
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    mode_d   = mode_q;
    tmo_d    = tmo_q;
    cnt_d    = cnt_q;
    mask_add = 1'b0;
    mask_clr = 1'b0;
    if (tmo_q) begin
      if (reset_cmd) begin
        tmo_d = 1'b0;
        if (mode_q == M_SPROG) begin
          mode_d = M_SUSP;
        end else begin
          mode_d   = M_IDLE;
          mask_clr = 1'b1;
        end
      end
    end else begin
      unique case (mode_q)
        M_IDLE: begin
          if (sec_erase_cmd) begin
            mode_d   = M_WIN;
            mask_add = 1'b1;
            cnt_d    = TLOAD;
          end else if (prog_start) begin
            mode_d = M_PROG;
          end
        end
        M_PROG: begin
          if (pulse_over)   tmo_d  = 1'b1;
          else if (op_done) mode_d = M_IDLE;
        end
        M_WIN: begin
          if (sec_erase_cmd) begin
            mask_add = 1'b1;
            cnt_d    = TLOAD;
          end else if (erase_susp) begin
            mode_d = M_SUSP;
          end else if (cnt_q == '0) begin
            mode_d = M_ERASE;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        M_ERASE: begin
          if (pulse_over) begin
            tmo_d = 1'b1;
          end else if (op_done) begin
            mode_d   = M_IDLE;
            mask_clr = 1'b1;
          end else if (erase_susp) begin
            mode_d = M_SUSP;
          end
        end
        M_SUSP: begin
          if (erase_resume)    mode_d = M_ERASE;
          else if (prog_start) mode_d = M_SPROG;
        end
        M_SPROG: begin
          if (pulse_over)   tmo_d  = 1'b1;
          else if (op_done) mode_d = M_SUSP;
        end
        default: mode_d = M_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_IDLE;
      tmo_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_d;
      tmo_q  <= tmo_d;
      cnt_q  <= cnt_d;
    end
  end

  assign mode    = mode_q;
  assign timeout = tmo_q;

  // R7
  tmo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_q && !reset_cmd |=> tmo_q);
  // R6
  win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_WIN) && !sec_erase_cmd && !erase_susp && (cnt_q != '0)
      |=> (mode_q == M_WIN));
  // R8
  rst_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_q && reset_cmd && (mode_q == M_SPROG) |=> (mode_q == M_SUSP) && !tmo_q);
endmodule

// File: rtl/fsg_sector_mask.sv
module fsg_sector_mask
  import fsg_pkg::*;
#(
  parameter int NUM_SEC = 8,
  localparam int SEC_W = (NUM_SEC > 1) ? $clog2(NUM_SEC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEC_W-1:0] sec_addr,
  input  logic             mask_add,
  input  logic             mask_clr,
  input  fsg_mode_e        mode,
  output logic             hit
);
  logic [NUM_SEC-1:0] mask_q, mask_d;

  for (genvar g = 0; g < NUM_SEC; g++) begin : g_bit
    always_comb begin
      if (mask_clr)
        mask_d[g] = 1'b0;
      else if (mask_add && (sec_addr == SEC_W'(g)))
        mask_d[g] = 1'b1;
      else
        mask_d[g] = mask_q[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  assign hit = (int'(sec_addr) < NUM_SEC) ? mask_q[sec_addr] : 1'b0;

  // R9
  idle_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_IDLE) |-> (mask_q == '0));
endmodule

// File: rtl/fsg_toggle.sv
module fsg_toggle
  import fsg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rd_evt,
  input  logic      hit,
  input  fsg_mode_e mode,
  output logic      tgl_act,
  output logic      tgl_sec
);
  logic act_q, act_d, sec_q, sec_d;
  logic act_en, sec_en;

  always_comb begin
    act_en = rd_evt && ((mode == M_PROG) || (mode == M_WIN) ||
                        (mode == M_ERASE) || (mode == M_SPROG));
    sec_en = rd_evt && hit && ((mode == M_WIN) || (mode == M_ERASE) ||
                               (mode == M_SUSP));
    act_d  = act_en ? ~act_q : act_q;
    sec_d  = sec_en ? ~sec_q : sec_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      sec_q <= 1'b0;
    end else begin
      act_q <= act_d;
      sec_q <= sec_d;
    end
  end

  assign tgl_act = act_q;
  assign tgl_sec = sec_q;

  // R2
  act_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_evt |=> $stable(act_q));
  // R3
  susp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SUSP) |=> $stable(act_q));
  // R5
  unsel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_evt && !hit |=> $stable(sec_q));
  // R2
  prog_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_evt && (mode == M_PROG) |=> (act_q != $past(act_q)));
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import fsg_pkg::*;
#(
  parameter int NUM_SEC = 8,
  parameter int TMO_CYC = 16,
  localparam int SEC_W = (NUM_SEC > 1) ? $clog2(NUM_SEC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEC_W-1:0] sec_addr,
  input  logic             rd_oe_end,
  input  logic             rd_ce_end,
  input  logic             prog_start,
  input  logic             sec_erase_cmd,
  input  logic             erase_susp,
  input  logic             erase_resume,
  input  logic             op_done,
  input  logic             pulse_over,
  input  logic             reset_cmd,
  output logic             stat_sel,
  output logic             st_tgl_act,
  output logic             st_tgl_sec,
  output logic             st_timeout,
  output logic             st_erase_go
);
  fsg_mode_e mode;
  logic      mask_add, mask_clr, hit, rd_evt;

  assign rd_evt = rd_oe_end | rd_ce_end;

  fsg_mode_ctl #(.TMO_CYC(TMO_CYC)) u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .prog_start   (prog_start),
    .sec_erase_cmd(sec_erase_cmd),
    .erase_susp   (erase_susp),
    .erase_resume (erase_resume),
    .op_done      (op_done),
    .pulse_over   (pulse_over),
    .reset_cmd    (reset_cmd),
    .mode         (mode),
    .timeout      (st_timeout),
    .mask_add     (mask_add),
    .mask_clr     (mask_clr)
  );

  fsg_sector_mask #(.NUM_SEC(NUM_SEC)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .sec_addr(sec_addr),
    .mask_add(mask_add),
    .mask_clr(mask_clr),
    .mode    (mode),
    .hit     (hit)
  );

  fsg_toggle u_tgl (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_evt (rd_evt),
    .hit    (hit),
    .mode   (mode),
    .tgl_act(st_tgl_act),
    .tgl_sec(st_tgl_sec)
  );

  assign stat_sel    = (mode != M_IDLE);
  assign st_erase_go = (mode == M_ERASE) || (mode == M_SUSP);

  // R6
  go_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_erase_cmd && !st_timeout && !st_erase_go |=> !st_erase_go);
endmodule

// File: tb/flash_status_gen_tb.sv
module flash_status_gen_tb;
  localparam int NS  = 8;
  localparam int TMO = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] sec_addr = '0;
  logic rd_oe_end = 0, rd_ce_end = 0, prog_start = 0, sec_erase_cmd = 0;
  logic erase_susp = 0, erase_resume = 0, op_done = 0, pulse_over = 0, reset_cmd = 0;
  logic stat_sel, st_tgl_act, st_tgl_sec, st_timeout, st_erase_go;

  int n_cmp = 0, n_bad = 0;
  logic e_act = 0, e_sec = 0;

  always #10 clk = ~clk;

  flash_status_gen #(.NUM_SEC(NS), .TMO_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .sec_addr(sec_addr),
    .rd_oe_end(rd_oe_end), .rd_ce_end(rd_ce_end), .prog_start(prog_start),
    .sec_erase_cmd(sec_erase_cmd), .erase_susp(erase_susp),
    .erase_resume(erase_resume), .op_done(op_done), .pulse_over(pulse_over),
    .reset_cmd(reset_cmd), .stat_sel(stat_sel), .st_tgl_act(st_tgl_act),
    .st_tgl_sec(st_tgl_sec), .st_timeout(st_timeout), .st_erase_go(st_erase_go)
  );

  task automatic chk(input string tag, input logic got, input logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%b exp=%b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one-cycle command strobe: 0 prog,1 erase,2 susp,3 resume,4 done,5 over,6 reset
  task automatic cmd(input int which, input int addr);
    sec_addr = 3'(addr);
    case (which)
      0: prog_start = 1;
      1: sec_erase_cmd = 1;
      2: erase_susp = 1;
      3: erase_resume = 1;
      4: op_done = 1;
      5: pulse_over = 1;
      default: reset_cmd = 1;
    endcase
    @(posedge clk);
    @(negedge clk);
    prog_start = 0; sec_erase_cmd = 0; erase_susp = 0; erase_resume = 0;
    op_done = 0; pulse_over = 0; reset_cmd = 0;
  endtask

  // status read; way: 0 oe, 1 ce, 2 both
  task automatic rd(input string tag, input int addr, input int way,
                    input logic t_act, input logic t_sec);
    sec_addr  = 3'(addr);
    rd_oe_end = (way != 1);
    rd_ce_end = (way != 0);
    @(posedge clk);
    @(negedge clk);
    rd_oe_end = 0;
    rd_ce_end = 0;
    if (t_act) e_act = ~e_act;
    if (t_sec) e_sec = ~e_sec;
    chk({tag, " act"}, st_tgl_act, e_act);
    chk({tag, " sec"}, st_tgl_sec, e_sec);
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    wait_cyc(3);
    rst_n = 1;
    wait_cyc(1);
    // R1 reset state
    chk("R1 sel", stat_sel, 0); chk("R1 act", st_tgl_act, 0);
    chk("R1 sec", st_tgl_sec, 0); chk("R1 tmo", st_timeout, 0);
    chk("R1 go", st_erase_go, 0);
    for (int a = 0; a < NS; a++) rd("R1 idle read", a, a % 3, 0, 0);

    // R2 program, all strobe ways; R5 sector bit holds
    cmd(0, 0);
    chk("R2 sel", stat_sel, 1);
    for (int w = 0; w < 3; w++)
      for (int a = 0; a < NS; a++) rd("R2/R5 prog", a, w, 1, 0);
    // R9 completion
    cmd(4, 0);
    chk("R9 sel", stat_sel, 0);
    for (int a = 0; a < NS; a++) rd("R9 after prog", a, 0, 0, 0);

    // R6 window with restart
    cmd(1, 2);
    chk("R6 go0", st_erase_go, 0);
    chk("R6 sel", stat_sel, 1);
    wait_cyc(8);
    cmd(1, 5);
    wait_cyc(TMO - 1);
    chk("R6 go before edge", st_erase_go, 0);
    wait_cyc(1);
    chk("R6 go at edge", st_erase_go, 1);
    // R4/R5 erase sweep
    for (int w = 0; w < 3; w++)
      for (int a = 0; a < NS; a++) rd("R4/R5 erase", a, w, 1, (a == 2) || (a == 5));
    // R10 suspend; R3 and R4 sweep
    cmd(2, 0);
    chk("R10 go in susp", st_erase_go, 1);
    for (int a = 0; a < NS; a++) rd("R3/R4 susp", a, a % 3, 0, (a == 2) || (a == 5));
    // R10 program in suspend
    cmd(0, 0);
    for (int a = 0; a < NS; a++) rd("R10/R5 sprog", a, 1, 1, 0);
    // R7 timeout latch, op_done ignored
    cmd(5, 0);
    chk("R7 tmo set", st_timeout, 1);
    cmd(4, 0);
    wait_cyc(4);
    chk("R7 tmo held", st_timeout, 1);
    rd("R7 still busy", 3, 0, 1, 0);
    // R8 reset back to suspend, mask kept
    cmd(6, 0);
    chk("R8 tmo clr", st_timeout, 0);
    chk("R8 sel susp", stat_sel, 1);
    rd("R8 susp sel", 5, 2, 0, 1);
    rd("R8 susp unsel", 4, 0, 0, 0);
    // R10 resume
    cmd(3, 0);
    rd("R10 resumed", 2, 0, 1, 1);
    // R7/R8 failure in erase -> idle
    cmd(5, 0);
    chk("R7 tmo erase", st_timeout, 1);
    cmd(6, 0);
    chk("R8 tmo clr2", st_timeout, 0);
    chk("R8 idle sel", stat_sel, 0);
    chk("R8 idle go", st_erase_go, 0);
    rd("R8 idle read", 2, 0, 0, 0);
    // R8 mask cleared: new erase of sector 7 only
    cmd(1, 7);
    rd("R8 old sec2", 2, 0, 1, 0);
    rd("R8 old sec5", 5, 1, 1, 0);
    rd("R8 new sec7", 7, 2, 1, 1);

    // R6 near-exhaustive: each single sector; suspend in window for R10
    cmd(4, 0); // ignored in window
    chk("R6 done ignored in window", stat_sel, 1);
    wait_cyc(TMO);
    chk("R6 go 7", st_erase_go, 1);
    cmd(4, 0);
    chk("R9 erase done", stat_sel, 0);
    for (int s = 0; s < NS; s++) begin
      cmd(1, s);
      wait_cyc(TMO - 1);
      chk("R6 sweep before", st_erase_go, 0);
      wait_cyc(1);
      chk("R6 sweep edge", st_erase_go, 1);
      for (int a = 0; a < NS; a++) rd("R4/R5 sweep", a, (a + s) % 3, 1, a == s);
      cmd(4, 0);
      for (int a = 0; a < NS; a++) rd("R9 sweep idle", a, 2, 0, 0);
    end
    // R10 suspend from the window
    cmd(1, 3);
    cmd(2, 0);
    chk("R10 win susp go", st_erase_go, 1);
    rd("R10 win susp", 3, 0, 0, 1);
    wait_cyc(TMO + 2);
    rd("R10 win susp stays", 3, 1, 0, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule